// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block runs ahead of an execution pipeline. It fetches instruction bytes from a word-wide bus and keeps them in a six-entry byte FIFO. The consumer takes one byte per handshake from the head of the FIFO. Each fetch address is a 20-bit sum: the code segment, moved up four bit positions, plus a 16-bit fetch pointer. A new fetch goes out only when there is room for a whole word, no fetch is already outstanding, and the execution side is not waiting for an operand cycle.

When the execution side needs an operand cycle, it raises a pending flag. The block grants the bus once any outstanding fetch has returned, and it issues no new fetch while the flag stays high. A redirect empties the FIFO and loads a new segment and pointer. Any fetch still outstanding at that moment is allowed to finish, but its data is thrown away.

The bus side uses a one-cycle start pulse with the address. It returns a one-cycle acknowledge with a 16-bit data word, at least one cycle later. Only one fetch can be outstanding at a time.

Top module: `fetch_queue`

## Requirements
- R1: The FIFO holds at most six bytes, and the consumer receives them in fetch-address order.
- R2: The fetch address equals segment × 16 + pointer, truncated to 20 bits.
- R3: A fetch starts only in these conditions: no fetch is outstanding, at most four bytes are held, the operand pending flag is low, and no redirect is present.
- R4: The operand grant is high exactly when the operand pending flag is high and no fetch is outstanding. An outstanding fetch is therefore always finished before the grant.
- R5: While the FIFO holds six bytes, no fetch starts, so the bus stays idle.
- R6: The byte valid output is low whenever the FIFO is empty. The consumer then waits until a byte arrives.
- R7: A redirect empties the FIFO in the next cycle, and the next fetch uses the new segment and pointer.
- R8: If a fetch is outstanding during a redirect, its returned data is discarded.
- R9: Byte lanes follow the address. Data bits 7:0 hold the byte at the even address and bits 15:8 hold the byte at the odd address. From an even pointer, a fetch loads two bytes and advances the pointer by 2. From an odd pointer, it loads only bits 15:8 and advances the pointer by 1.
- R10: The pointer wraps within 16 bits, and the segment-plus-pointer sum wraps within 20 bits.
- R11: After reset, the FIFO is empty and the first fetch address is segment FFFF, pointer 0000 (address FFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Flush the FIFO and load a new target |
| redirect_seg | input | 16 | New code segment |
| redirect_off | input | 16 | New fetch pointer |
| opr_pending | input | 1 | Execution side wants an operand cycle |
| opr_go | output | 1 | Operand cycle may use the bus |
| fetch_start | output | 1 | Fetch request pulse |
| fetch_addr | output | 20 | Fetch address |
| fetch_ack | input | 1 | Fetch data returned |
| fetch_data | input | 16 | Returned word |
| byte_valid | output | 1 | Head byte available |
| byte_data | output | 8 | Head byte |
| byte_ready | input | 1 | Consumer takes the head byte |

## Verification
Three pairs of events can land in the same cycle:
- a redirect and the return of an outstanding fetch;
- a fetch return and a consumer pop;
- an operand request and a fetch that is still in flight.

The bench uses a bus model with adjustable latency and a consumer whose ready pattern is throttled. It issues redirects right after a fetch starts, and it raises the operand flag one cycle after a fetch start. A shadow occupancy and outstanding-fetch model then judges every cycle: valid, grant and start must match it, and a scoreboard rejects any byte from a dropped fetch.

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int DEPTH = 6,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        redirect,
  input  logic [15:0] redirect_seg,
  input  logic [15:0] redirect_off,
  input  logic        opr_pending,
  output logic        opr_go,
  output logic        fetch_start,
  output logic [19:0] fetch_addr,
  input  logic        fetch_ack,
  input  logic [15:0] fetch_data,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  input  logic        byte_ready
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

  logic [15:0]   seg_q, ptr_q;
  logic [CW-1:0] cnt_q, cnt_pop, cnt_nx;
  logic [7:0]    q_q  [DEPTH];
  logic [7:0]    q_nx [DEPTH];
  logic          busy_q, stale_q, odd_q;
  logic          pop, take;

  assign pop         = byte_valid && byte_ready;
  assign take        = fetch_ack && busy_q && !stale_q && !redirect;
  assign byte_valid  = cnt_q != '0;
  assign byte_data   = q_q[0];
  assign opr_go      = opr_pending && !busy_q;
  assign fetch_start = !busy_q && !opr_pending && !redirect && (cnt_q <= ROOM_MAX);
  assign fetch_addr  = {seg_q, 4'h0} + {4'h0, ptr_q};
  assign cnt_pop     = cnt_q - CW'(pop);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = (i + 1 < DEPTH) ? i + 1 : i;
      q_nx[i] = pop ? q_q[j] : q_q[i];
      if (take) begin
        if (CW'(i) == cnt_pop)
          q_nx[i] = odd_q ? fetch_data[15:8] : fetch_data[7:0];
        if (!odd_q && CW'(i) == cnt_pop + CW'(1))
          q_nx[i] = fetch_data[15:8];
      end
    end
    cnt_nx = cnt_pop + (take ? (odd_q ? CW'(1) : CW'(2)) : '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) q_q[i] <= q_nx[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seg_q   <= RESET_SEG;
      ptr_q   <= RESET_OFF;
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      odd_q   <= 1'b0;
    end else if (redirect) begin
      cnt_q   <= '0;
      seg_q   <= redirect_seg;
      ptr_q   <= redirect_off;
      busy_q  <= busy_q && !fetch_ack;
      stale_q <= busy_q && !fetch_ack;
    end else begin
      cnt_q <= cnt_nx;
      if (fetch_start) begin
        busy_q <= 1'b1;
        odd_q  <= ptr_q[0];
        ptr_q  <= ptr_q + (ptr_q[0] ? 16'd1 : 16'd2);
      end else if (fetch_ack && busy_q) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
      end
    end
  end

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> busy_q && !fetch_start);
  a_r4_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    opr_pending && busy_q && !fetch_ack |=> !opr_go);
  a_r5_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'(DEPTH) |-> !fetch_start);
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !byte_valid);
  a_r9_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start && ptr_q[0] |=> ptr_q == $past(ptr_q) + 16'd1);
  a_r9_even_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start && !ptr_q[0] |=> ptr_q == $past(ptr_q) + 16'd2);
endmodule

// File: tb/fetch_queue_test.sv
module fetch_queue_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        redirect = 1'b0, opr_pending = 1'b0;
  logic [15:0] redirect_seg = '0, redirect_off = '0;
  logic        opr_go, fetch_start, byte_valid;
  logic [19:0] fetch_addr;
  logic        fetch_ack = 1'b0, byte_ready = 1'b0;
  logic [15:0] fetch_data = '0;
  logic [7:0]  byte_data;

  fetch_queue uut (.*);

  always #4 clk = ~clk;

  int vec = 0, bad = 0;
  bit [7:0] exp_q[$];
  int lat = 1, rmode = 1, cyc = 0, occ = 0, lat_cnt = 0;
  int starts_win = 0, opr_seen = 0, drops = 0, p_nb = 0;
  bit busy_b = 0, stale_b = 0, odd_b = 0, p_drop = 0, p_redir = 0, p_pop = 0, p_ack = 0;
  bit done = 0;
  logic [15:0] exp_seg = 16'hFFFF, exp_foff = 16'h0000, tseg, toff;
  logic [19:0] waddr = '0;

  function automatic [7:0] memb(input [19:0] a);
    memb = a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
  endfunction

  function automatic [19:0] lin(input [15:0] s, input [15:0] o);
    lin = {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // bus model, consumer and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      occ = 0; lat_cnt = 0; busy_b = 0; stale_b = 0;
      p_redir = 0; p_pop = 0; p_ack = 0; fetch_ack = 0; byte_ready = 0;
    end else begin
      if (p_redir) occ = 0;
      else begin
        if (p_pop) occ--;
        if (p_ack && !p_drop) occ += p_nb;
      end
      if (p_ack) begin
        if (p_drop) drops++;
        busy_b = 0; stale_b = 0;
      end
      fetch_ack = 0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          fetch_ack  = 1;
          fetch_data = {memb(waddr | 20'd1), memb(waddr)};
          p_nb   = odd_b ? 1 : 2;
          p_drop = stale_b;
        end
      end
      byte_ready = !redirect && exp_q.size() > 0 &&
                   (rmode == 1 || (rmode == 2 && cyc % 3 == 0));
      if (byte_valid !== (occ != 0)) chk(0, "R6 valid vs occupancy", byte_valid, occ != 0);
      if (occ > 6) chk(0, "R1 occupancy bound", occ, 6);
      if (byte_valid && byte_ready) begin
        bit [7:0] e;
        e = exp_q.pop_front();
        chk(byte_data === e, "R1 byte order", byte_data, e);
      end
      if (opr_go !== (opr_pending && !busy_b)) chk(0, "R4 operand grant", opr_go, opr_pending && !busy_b);
      if (opr_go) opr_seen++;
      if (fetch_start) begin
        chk(!(occ > 4 || busy_b || opr_pending || redirect), "R3 start gate", occ, 4);
        chk(fetch_addr === lin(exp_seg, exp_foff), "R2 R10 fetch address", fetch_addr, lin(exp_seg, exp_foff));
        waddr = {fetch_addr[19:1], 1'b0};
        odd_b = exp_foff[0];
        exp_foff = exp_foff + (exp_foff[0] ? 16'd1 : 16'd2);
        busy_b = 1; lat_cnt = lat; starts_win++;
      end
      if (redirect) begin
        if (fetch_ack) p_drop = 1;
        else if (busy_b) stale_b = 1;
        exp_seg = tseg; exp_foff = toff;
      end
      p_redir = redirect;
      p_pop   = byte_valid && byte_ready;
      p_ack   = fetch_ack;
    end
  end

  task automatic branch(input logic [15:0] s, input logic [15:0] o, input int n);
    @(posedge clk); #1;
    exp_q.delete();
    for (int k = 0; k < n; k++) exp_q.push_back(memb(lin(s, o + 16'(k))));
    tseg = s; toff = o;
    redirect_seg = s; redirect_off = o; redirect = 1;
    @(posedge clk); #1 redirect = 0;
  endtask

  task automatic drain();
    rmode = (rmode == 0) ? 1 : rmode;
    while (exp_q.size() > 0) @(negedge clk);
    chk(1, "drain", 0, 0);
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!fetch_start) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    for (int k = 0; k < 20; k++) exp_q.push_back(memb(lin(16'hFFFF, 16'(k))));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(byte_valid === 1'b0, "R11 empty after reset", byte_valid, 0);
    chk(fetch_start === 1'b1, "R11 first fetch issued", fetch_start, 1);
    chk(fetch_addr === 20'hFFFF0, "R11 reset address", fetch_addr, 20'hFFFF0);
    drain();

    // R9 odd target, slow bus, sparse consumer
    lat = 3; rmode = 2;
    branch(16'h1234, 16'h0101, 24);
    drain();

    // R10 20-bit sum wrap (odd) and 16-bit pointer wrap
    lat = 2; rmode = 1;
    branch(16'hFFFF, 16'h0011, 12);
    drain();
    branch(16'h1000, 16'hFFFD, 12);
    drain();

    // R5 full queue keeps bus idle
    lat = 1; rmode = 0;
    branch(16'h0300, 16'h0020, 30);
    repeat (20) @(negedge clk);
    starts_win = 0;
    repeat (12) @(negedge clk);
    chk(starts_win == 0, "R5 idle when full", starts_win, 0);
    chk(occ == 6 && byte_valid, "R5 queue full", occ, 6);
    // R7 redirect while full
    branch(16'h0400, 16'h0002, 10);
    chk(byte_valid === 1'b0, "R7 flushed", byte_valid, 0);
    rmode = 1;
    drain();

    // R4 operand request during an outstanding fetch
    lat = 3; rmode = 1;
    branch(16'h2000, 16'h0040, 40);
    wait_start();
    @(posedge clk); #1 opr_pending = 1; opr_seen = 0;
    @(negedge clk);
    chk(opr_go === 1'b0, "R4 fetch finishes first", opr_go, 0);
    repeat (8) @(posedge clk);
    #1 opr_pending = 0;
    chk(opr_seen > 0, "R4 grant after fetch", opr_seen, 1);
    drain();

    // R8 redirect with a fetch in flight
    lat = 4; drops = 0;
    branch(16'h5000, 16'h0010, 8);
    wait_start();
    branch(16'h6000, 16'h0031, 14);
    drain();
    chk(drops > 0, "R8 stale fetch dropped", drops, 1);

    // R8 redirect in the same cycle as an acknowledge
    lat = 1; drops = 0;
    branch(16'h7000, 16'h0000, 6);
    wait_start();
    branch(16'h7100, 16'h0008, 10);
    drain();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule